// File: doc/BRIEF.md
# 8-bit CPU ALU and flag unit

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each cycle it takes a 4-bit operation code, the accumulator, the two index registers, an operand byte and the current four status flags. From these it produces, without any clock, a result byte, the next flag values and two steering bits. The steering bits say whether the result should be stored and whether it goes to the X register instead of the accumulator.

A small flag register sits beside the datapath. It takes the computed flags on any clock edge where the update enable is high. The surrounding core decodes instructions, owns the data registers and feeds the registered flags back as the current flags on the next operation. Arithmetic is always binary.

Top module: `cpu8_alu`

## Requirements
- R1: Op 0 (add with carry) forms the 9-bit sum acc + operand + C. The result is the low byte. C becomes sum bit 8. V is set when the signed sum falls outside -128..127. Z and N follow R9. The result is written to the accumulator.
- R2: Op 1 (subtract with borrow) computes acc - operand - (1 - C). C is set when acc >= operand + (1 - C), meaning no borrow. V is set when the signed difference falls outside -128..127. Z and N follow R9. The result is written to the accumulator.
- R3: Ops 2, 3 and 4 compare the operand against acc, X and Y respectively. C is set when the register is >= the operand. Z and N come from the 8-bit difference, which appears on the result port. V is kept and nothing is written.
- R4: Op 5 (bit test) sets Z when (acc AND operand) is zero. It loads N from operand bit 7 and V from operand bit 6. C is kept, the result port shows acc AND operand, and nothing is written.
- R5: Ops 6, 7 and 8 give acc AND, OR and XOR the operand. They are written to the accumulator and change only Z and N.
- R6: Op 9 returns operand + 1 and op 10 returns operand - 1, both modulo 256. Each is written and changes only Z and N, so C and V are kept.
- R7: Op 11 shifts the operand left, moving bit 7 into C and a zero into bit 0. Op 12 shifts it right, moving bit 0 into C and a zero into bit 7, so N is always cleared. Both are written and keep V.
- R8: Op 13 computes (acc AND X) - operand. The low byte is written to X. C is set when (acc AND X) >= operand, Z and N come from the result, and V is kept.
- R9: Flag bits are [0]=C, [1]=Z, [2]=V, [3]=N. Every written result sets Z when the result byte is zero and copies result bit 7 into N.
- R10: Ops 14 and 15 pass the operand to the result port. They leave all four flags unchanged and write nothing.
- R11: The flag register clears to 0000 on reset. It loads the next flags on a clock edge when the update enable is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| flag_we | input | 1 | Load the next flags into the flag register at the clock edge |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator |
| xr | input | 8 | X register |
| yr | input | 8 | Y register |
| opnd | input | 8 | Operand byte |
| flg_in | input | 4 | Current flags {N,V,Z,C} |
| result | output | 8 | Result byte |
| res_wr | output | 1 | Result is to be stored |
| res_to_x | output | 1 | Stored result targets X rather than the accumulator |
| flg_nxt | output | 4 | Next flags {N,V,Z,C} |
| flg_q | output | 4 | Registered flags |

## Verification
The datapath has no internal state, so a wrong carry chain, borrow polarity or flag mask shows up at result and flg_nxt in the same delta as the inputs change. The bench sweeps every accumulator value against a spread of operands with both carry values for all sixteen codes, and derives expected values from signed and unsigned integer arithmetic. The only state is the flag register. A load or hold error there appears on flg_q one clock after the edge in question, and the bench checks that both after a long hold and after explicit loads.

// File: rtl/cpu8_alu.sv
module cpu8_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_we,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] xr,
  input  logic [W-1:0] yr,
  input  logic [W-1:0] opnd,
  input  logic [3:0]   flg_in,
  output logic [W-1:0] result,
  output logic         res_wr,
  output logic         res_to_x,
  output logic [3:0]   flg_nxt,
  output logic [3:0]   flg_q
);
  localparam logic [3:0] OP_ADC = 4'd0,  OP_SBC = 4'd1,  OP_CPA = 4'd2,  OP_CPX = 4'd3;
  localparam logic [3:0] OP_CPY = 4'd4,  OP_BIT = 4'd5,  OP_AND = 4'd6,  OP_ORA = 4'd7;
  localparam logic [3:0] OP_EOR = 4'd8,  OP_INC = 4'd9,  OP_DEC = 4'd10, OP_SHL = 4'd11;
  localparam logic [3:0] OP_SHR = 4'd12, OP_AXS = 4'd13;
  localparam int MSB = W - 1;

  logic [W:0]   sum, dif, cmpd, axd;
  logic [W-1:0] csrc, andax;
  logic         c, z, v, n, zn_upd;

  assign andax = acc & xr;
  assign csrc  = (op == OP_CPX) ? xr : (op == OP_CPY) ? yr : acc;
  assign sum   = {1'b0, acc} + {1'b0, opnd} + {{W{1'b0}}, flg_in[0]};
  assign dif   = {1'b0, acc} - {1'b0, opnd} - {{W{1'b0}}, ~flg_in[0]};
  assign cmpd  = {1'b0, csrc} - {1'b0, opnd};
  assign axd   = {1'b0, andax} - {1'b0, opnd};

  always_comb begin
    result   = opnd;
    res_wr   = 1'b0;
    res_to_x = 1'b0;
    zn_upd   = 1'b0;
    c = flg_in[0];
    z = flg_in[1];
    v = flg_in[2];
    n = flg_in[3];
    case (op)
      OP_ADC: begin
        result = sum[MSB:0]; res_wr = 1'b1; zn_upd = 1'b1;
        c = sum[W];
        v = ~(acc[MSB] ^ opnd[MSB]) & (acc[MSB] ^ sum[MSB]);
      end
      OP_SBC: begin
        result = dif[MSB:0]; res_wr = 1'b1; zn_upd = 1'b1;
        c = ~dif[W];
        v = (acc[MSB] ^ dif[MSB]) & (acc[MSB] ^ opnd[MSB]);
      end
      OP_CPA, OP_CPX, OP_CPY: begin
        result = cmpd[MSB:0]; zn_upd = 1'b1;
        c = ~cmpd[W];
      end
      OP_BIT: begin
        result = acc & opnd;
        z = ((acc & opnd) == '0);
        n = opnd[MSB];
        v = opnd[MSB-1];
      end
      OP_AND: begin result = acc & opnd; res_wr = 1'b1; zn_upd = 1'b1; end
      OP_ORA: begin result = acc | opnd; res_wr = 1'b1; zn_upd = 1'b1; end
      OP_EOR: begin result = acc ^ opnd; res_wr = 1'b1; zn_upd = 1'b1; end
      OP_INC: begin result = opnd + 1'b1; res_wr = 1'b1; zn_upd = 1'b1; end
      OP_DEC: begin result = opnd - 1'b1; res_wr = 1'b1; zn_upd = 1'b1; end
      OP_SHL: begin
        result = {opnd[MSB-1:0], 1'b0}; res_wr = 1'b1; zn_upd = 1'b1;
        c = opnd[MSB];
      end
      OP_SHR: begin
        result = {1'b0, opnd[MSB:1]}; res_wr = 1'b1; zn_upd = 1'b1;
        c = opnd[0];
      end
      OP_AXS: begin
        result = axd[MSB:0]; res_wr = 1'b1; res_to_x = 1'b1; zn_upd = 1'b1;
        c = ~axd[W];
      end
      default: ;
    endcase
    if (zn_upd) begin
      z = (result == '0);
      n = result[MSB];
    end
  end

  assign flg_nxt = {n, v, z, c};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flg_q <= 4'b0000;
    else if (flag_we) flg_q <= flg_nxt;

  AST_INCDEC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC || op == OP_DEC) |-> (flg_nxt[0] == flg_in[0] && flg_nxt[2] == flg_in[2])); // R6
  AST_SHR_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHR) |-> (flg_nxt[3] == 1'b0 && result[MSB] == 1'b0)); // R7
  AST_X_ONLY_AXS: assert property (@(posedge clk) disable iff (!rst_n)
    res_to_x |-> (res_wr && op == OP_AXS)); // R8
  AST_WRITTEN_ZN: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |-> (flg_nxt[1] == (result == '0) && flg_nxt[3] == result[MSB])); // R9
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op[3:1] == 3'b111) |-> (!res_wr && flg_nxt == flg_in)); // R10
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flg_q == $past(flg_nxt))); // R11
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flg_q)); // R11
endmodule

// File: tb/cpu8_alu_bench.sv
module cpu8_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flag_we = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc = '0, xr = '0, yr = '0, opnd = '0;
  logic [3:0] flg_in = '0;
  logic [7:0] result;
  logic       res_wr, res_to_x;
  logic [3:0] flg_nxt, flg_q;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpu8_alu u_cpu8_alu (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .op(op), .acc(acc), .xr(xr), .yr(yr),
    .opnd(opnd), .flg_in(flg_in), .result(result), .res_wr(res_wr), .res_to_x(res_to_x),
    .flg_nxt(flg_nxt), .flg_q(flg_q));

  function automatic string req_of(input int o);
    case (o)
      0: return "R1";  1: return "R2";  2, 3, 4: return "R3";  5: return "R4";
      6, 7, 8: return "R5";  9, 10: return "R6";  11, 12: return "R7";  13: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic int sx(input int b);
    return (b > 127) ? b - 256 : b;
  endfunction

  task automatic model(input int o, input int a, input int x, input int y, input int m,
                       input logic [3:0] fi, output logic [7:0] er, output logic ew,
                       output logic ex, output logic [3:0] ef);
    int r, sr, ci, bw, t;
    logic c, z, v, n;
    bit zn;
    c = fi[0]; z = fi[1]; v = fi[2]; n = fi[3];
    ci = int'(fi[0]); bw = 1 - ci;
    r = m; ew = 1'b0; ex = 1'b0; zn = 1'b0;
    case (o)
      0: begin r = a + m + ci; c = (r > 255); sr = sx(a) + sx(m) + ci;
               v = (sr < -128 || sr > 127); ew = 1'b1; zn = 1'b1; end
      1: begin r = a - m - bw; c = (a >= m + bw); sr = sx(a) - sx(m) - bw;
               v = (sr < -128 || sr > 127); ew = 1'b1; zn = 1'b1; end
      2: begin r = a - m; c = (a >= m); zn = 1'b1; end
      3: begin r = x - m; c = (x >= m); zn = 1'b1; end
      4: begin r = y - m; c = (y >= m); zn = 1'b1; end
      5: begin r = a & m; z = (r == 0); n = (m >= 128); v = ((m % 128) >= 64); end
      6: begin r = a & m; ew = 1'b1; zn = 1'b1; end
      7: begin r = a | m; ew = 1'b1; zn = 1'b1; end
      8: begin r = a ^ m; ew = 1'b1; zn = 1'b1; end
      9: begin r = m + 1; ew = 1'b1; zn = 1'b1; end
      10: begin r = m - 1; ew = 1'b1; zn = 1'b1; end
      11: begin c = (m >= 128); r = m * 2; ew = 1'b1; zn = 1'b1; end
      12: begin c = (m % 2 == 1); r = m / 2; ew = 1'b1; zn = 1'b1; end
      13: begin t = a & x; r = t - m; c = (t >= m); ew = 1'b1; ex = 1'b1; zn = 1'b1; end
      default: ;
    endcase
    r = ((r % 256) + 256) % 256;
    er = 8'(r);
    if (zn) begin z = (r == 0); n = (r >= 128); end
    ef = {n, v, z, c};
  endtask

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s op=%0d acc=%02h opnd=%02h: actual %0h expected %0h",
               rq, what, op, acc, opnd, act, exp);
    end
  endtask

  initial begin
    #100000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] er;
    logic ew, ex;
    logic [3:0] ef;
    #1;
    chk("R11", "flg_q in reset", int'(flg_q), 0);
    #10 rst_n = 1'b1;
    // Sweep of all codes: every acc, 16 operands, both carries (R9 covered by every written op).
    for (int o = 0; o < 16; o++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 16; k++) begin
          for (int c = 0; c < 2; c++) begin
            op = 4'(o); acc = 8'(a); xr = 8'(a ^ 8'h5A); yr = 8'(255 - a);
            opnd = 8'((k * 17 + a / 16) % 256);
            flg_in = {acc[3], acc[2], acc[1], 1'(c)};
            #1;
            model(o, a, int'(xr), int'(yr), int'(opnd), flg_in, er, ew, ex, ef);
            chk(req_of(o), "result", int'(result), int'(er));
            chk(req_of(o), "flags", int'(flg_nxt), int'(ef));
            chk(req_of(o), "res_wr", int'(res_wr), int'(ew));
            chk(req_of(o), "res_to_x", int'(res_to_x), int'(ex));
          end
        end
      end
    end
    // Corner cases named explicitly.
    op = 4'd0; acc = 8'h7F; opnd = 8'h01; flg_in = 4'b0000; #1;
    chk("R1", "0x7F+1 flags", int'(flg_nxt), 4'b1100);
    op = 4'd1; acc = 8'h80; opnd = 8'h01; flg_in = 4'b0001; #1;
    chk("R2", "0x80-1 flags", int'(flg_nxt), 4'b0101);
    op = 4'd2; acc = 8'h40; opnd = 8'h40; flg_in = 4'b0100; #1;
    chk("R3", "equal compare flags", int'(flg_nxt), 4'b0111);
    op = 4'd12; opnd = 8'hFF; flg_in = 4'b1000; #1;
    chk("R7", "shift right N", int'(flg_nxt), 4'b0001);
    op = 4'd9; opnd = 8'hFF; flg_in = 4'b0101; #1;
    chk("R6", "inc wrap result", int'(result), 0);
    chk("R6", "inc wrap flags", int'(flg_nxt), 4'b0111);
    // Flag register: held through the sweep with flag_we low, then loaded.
    @(negedge clk);
    chk("R11", "flg_q held", int'(flg_q), 0);
    op = 4'd5; acc = 8'h00; opnd = 8'hC0; flg_in = 4'b0001; flag_we = 1'b1;
    @(negedge clk);
    chk("R11", "flg_q loaded", int'(flg_q), 4'b1111);
    flag_we = 1'b0; op = 4'd6; acc = 8'h01; opnd = 8'h01; flg_in = 4'b0000;
    @(negedge clk); @(negedge clk);
    chk("R11", "flg_q hold with we low", int'(flg_q), 4'b1111);
    flag_we = 1'b1;
    @(negedge clk);
    chk("R11", "flg_q reload", int'(flg_q), 4'b0000);
    flag_we = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule